// File: doc/BRIEF.md
# Memory-Mapped Data Memory Decoder

This block is the data side of a small 16-bit processor's memory system. A single word-wide read/write port faces the CPU, and the block steers each access by address to one of three regions. The regions are general-purpose RAM, a pixel frame buffer for a monochrome display, and a one-word keyboard register. The RAM and the frame buffer are internal storage arrays. The keyboard word is not storage the CPU can write. It is a register that samples an external key-code input on every clock. The frame buffer also has a second, read-only port, so a display engine can fetch pixels without taking cycles from the CPU.

The address space is split by fixed fractions of a parameterised width `ADDR_W`. The lower half is RAM. The next quarter is the frame buffer. The first word of the top quarter is the keyboard. Every word above the keyboard is an unbacked hole. With `ADDR_W = 15` this gives 16K RAM words at 0x0000-0x3FFF, 8K frame-buffer words at 0x4000-0x5FFF (512x256 one-bit pixels) and the keyboard at 0x6000. The default is a reduced width of 11: RAM at 0x000-0x3FF, frame buffer at 0x400-0x5FF, keyboard at 0x600, and a hole at 0x601-0x7FF.

Top module: `data_mem_map`

## Requirements
- R1: For an address with its top bit clear (RAM region), a write with `we_i` high stores `wdata_i` at the rising clock edge. Reads of RAM are combinational: `rdata_o` shows the stored word in the same cycle the address is applied.
- R2: For an address whose top two bits are `10` (frame-buffer region), writes and combinational reads behave as in R1. The word is selected by the low `ADDR_W-2` address bits.
- R3: At the keyboard address (top two bits `11`, all other bits zero), `rdata_o` returns the value `key_i` had at the previous rising edge. A value of 0 means no key is pressed.
- R4: A write to the keyboard address changes no stored word and does not change what the keyboard address reads.
- R5: Addresses above the keyboard address read 0. Writes to them are discarded and change no stored word.
- R6: A write to any address changes no other address's read value. Nothing aliases between or within regions.
- R7: `disp_data_o` combinationally returns the frame-buffer word at `disp_addr_i`. This is the same storage that CPU address `FB_BASE + disp_addr_i` reads.
- R8: With `we_i` low, a clock edge leaves every stored word unchanged.
- R9: While `rst_ni` is low, and in the first cycle after it rises, the keyboard word reads 0 whatever `key_i` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset (keyboard register only) |
| addr_i | input | ADDR_W | CPU word address |
| wdata_i | input | DATA_W | CPU write data |
| we_i | input | 1 | CPU write enable |
| rdata_o | output | DATA_W | CPU read data, combinational from `addr_i` |
| key_i | input | DATA_W | Current key code from the keyboard, 0 when idle |
| disp_addr_i | input | ADDR_W-2 | Display fetch address within the frame buffer |
| disp_data_o | output | DATA_W | Display fetch data, combinational |

## Verification
Most internal faults in this block show up at the ports within one clock edge. A wrong region decode or a wrong write strobe corrupts a word in some other region. Every address is written with a pattern that depends on the address itself, and every address is read back afterwards, so a corrupted word appears at the read-back of the victim address. A stale or unreset keyboard register appears on `rdata_o` in the first cycle the keyboard address is selected. A mis-wired display port returns a neighbour's pattern on the first fetch.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
  typedef enum logic [1:0] {
    RG_RAM  = 2'd0,
    RG_FB   = 2'd1,
    RG_KEY  = 2'd2,
    RG_NONE = 2'd3
  } region_e;
endpackage

// File: rtl/dmem_decode.sv
module dmem_decode
  import dmem_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  output region_e           region_o,
  output logic              ram_we_o,
  output logic              fb_we_o
);
  localparam int LOW_W = ADDR_W - 2;

  always_comb begin
    if (!addr_i[ADDR_W-1])                region_o = RG_RAM;
    else if (!addr_i[ADDR_W-2])           region_o = RG_FB;
    else if (addr_i[LOW_W-1:0] == '0)     region_o = RG_KEY;
    else                                  region_o = RG_NONE;
  end

  assign ram_we_o = we_i && (region_o == RG_RAM);
  assign fb_we_o  = we_i && (region_o == RG_FB);
endmodule

// File: rtl/dmem_bank.sv
module dmem_bank #(
  parameter int AW     = 10,
  parameter int DATA_W = 16,
  parameter int N_RD   = 1
) (
  input  logic                       clk_i,
  input  logic                       we_i,
  input  logic [AW-1:0]              waddr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  input  logic [N_RD-1:0][AW-1:0]    rd_addr_i,
  output logic [N_RD-1:0][DATA_W-1:0] rd_data_o
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  for (genvar p = 0; p < N_RD; p++) begin : g_rd
    assign rd_data_o[p] = mem_q[rd_addr_i[p]];
  end
endmodule

// File: rtl/data_mem_map.sv
module data_mem_map
  import dmem_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [DATA_W-1:0] key_i,
  input  logic [ADDR_W-3:0] disp_addr_i,
  output logic [DATA_W-1:0] disp_data_o
);
  localparam int RAM_AW = ADDR_W - 1;
  localparam int FB_AW  = ADDR_W - 2;

  region_e           region;
  logic              ram_we, fb_we;
  logic [DATA_W-1:0] ram_rd;
  logic [1:0][DATA_W-1:0] fb_rd;
  logic [DATA_W-1:0] key_q;

  dmem_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i   (addr_i),
    .we_i     (we_i),
    .region_o (region),
    .ram_we_o (ram_we),
    .fb_we_o  (fb_we)
  );

  dmem_bank #(.AW(RAM_AW), .DATA_W(DATA_W), .N_RD(1)) u_ram (
    .clk_i     (clk_i),
    .we_i      (ram_we),
    .waddr_i   (addr_i[RAM_AW-1:0]),
    .wdata_i   (wdata_i),
    .rd_addr_i (addr_i[RAM_AW-1:0]),
    .rd_data_o (ram_rd)
  );

  // port 0: CPU, port 1: display fetch
  dmem_bank #(.AW(FB_AW), .DATA_W(DATA_W), .N_RD(2)) u_fb (
    .clk_i     (clk_i),
    .we_i      (fb_we),
    .waddr_i   (addr_i[FB_AW-1:0]),
    .wdata_i   (wdata_i),
    .rd_addr_i ({disp_addr_i, addr_i[FB_AW-1:0]}),
    .rd_data_o (fb_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) key_q <= '0;
    else         key_q <= key_i;
  end

  always_comb begin
    unique case (region)
      RG_RAM:  rdata_o = ram_rd;
      RG_FB:   rdata_o = fb_rd[0];
      RG_KEY:  rdata_o = key_q;
      default: rdata_o = '0;
    endcase
  end

  assign disp_data_o = fb_rd[1];
endmodule

// File: rtl/dmem_checker.sv
module dmem_checker #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              we_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [DATA_W-1:0] key_i,
  input logic [ADDR_W-3:0] disp_addr_i,
  input logic [DATA_W-1:0] disp_data_o,
  input logic              ram_we,
  input logic              fb_we
);
  localparam int FB_AW = ADDR_W - 2;
  localparam logic [ADDR_W-1:0] KEY_ADDR = ADDR_W'(3) << FB_AW;

  logic in_ram, in_fb, in_hole;
  assign in_ram  = !addr_i[ADDR_W-1];
  assign in_fb   = addr_i[ADDR_W-1:ADDR_W-2] == 2'b10;
  assign in_hole = addr_i > KEY_ADDR;

  a_r6_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ram_we, fb_we}));

  a_r4_no_store_outside: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_ram || in_fb) |-> !ram_we && !fb_we);

  a_r8_idle_no_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |-> !ram_we && !fb_we);

  a_r5_hole_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_hole |-> rdata_o == '0);

  a_r3_key_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == KEY_ADDR && $past(rst_ni)) |-> rdata_o == $past(key_i));

  a_r1_ram_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && in_ram) |=> (addr_i != $past(addr_i) || rdata_o == $past(wdata_i)));

  a_r2_fb_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && in_fb) |=> (addr_i != $past(addr_i) || rdata_o == $past(wdata_i)));

  a_r7_disp_sees_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && in_fb) |=> (disp_addr_i != $past(addr_i[FB_AW-1:0]) ||
                         disp_data_o == $past(wdata_i)));
endmodule

bind data_mem_map dmem_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .we_i        (we_i),
  .rdata_o     (rdata_o),
  .key_i       (key_i),
  .disp_addr_i (disp_addr_i),
  .disp_data_o (disp_data_o),
  .ram_we      (ram_we),
  .fb_we       (fb_we)
);

// File: tb/data_mem_map_tb.sv
module data_mem_map_tb;
  localparam int AW = 11;
  localparam int DW = 16;
  localparam int SPACE    = 1 << AW;
  localparam int FB_BASE  = SPACE / 2;
  localparam int FB_SIZE  = SPACE / 4;
  localparam int KEY_ADDR = FB_BASE + FB_SIZE;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          we = 1'b0;
  logic [DW-1:0] rdata;
  logic [DW-1:0] key = '0;
  logic [AW-3:0] disp_addr = '0;
  logic [DW-1:0] disp_data;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  data_mem_map #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .rdata_o(rdata), .key_i(key), .disp_addr_i(disp_addr), .disp_data_o(disp_data)
  );

  function automatic logic [DW-1:0] pat(int a, int salt);
    return DW'((a * 40503 + salt) ^ (a << 5));
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [DW-1:0] d, logic en);
    @(negedge clk);
    addr = AW'(a); wdata = d; we = en;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_chk(string req, int a, logic [DW-1:0] exp);
    addr = AW'(a);
    #1;
    chk(req, rdata, exp);
  endtask

  function automatic logic [DW-1:0] expect_word(int a);
    if (a < FB_BASE + FB_SIZE) return pat(a, 7);
    if (a == KEY_ADDR) return 16'h0000;
    return 16'h0000;
  endfunction

  initial begin
    #4_000_000;
    bad++; total++;
    $display("FAIL watchdog: act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R9: reset holds keyboard at 0
    key = 16'h1234;
    addr = AW'(KEY_ADDR);
    #35;
    chk("R9 in reset", rdata, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R9 after release", rdata, 16'h0000);
    key = 16'h0000;
    @(negedge clk);

    // R1 R2 R6: fill RAM then frame buffer with address-dependent words
    for (int a = 0; a < FB_BASE + FB_SIZE; a++) wr(a, pat(a, 7), 1'b1);
    // R4 R5: writes to keyboard and hole must land nowhere
    wr(KEY_ADDR, 16'hBEEF, 1'b1);
    for (int a = KEY_ADDR + 1; a < SPACE; a++) wr(a, pat(a, 99), 1'b1);

    // full read-back sweep
    @(negedge clk);
    for (int a = 0; a < SPACE; a++) begin
      if (a < FB_BASE)         rd_chk("R1/R6 ram readback", a, expect_word(a));
      else if (a < KEY_ADDR)   rd_chk("R2/R6 fb readback", a, expect_word(a));
      else if (a == KEY_ADDR)  rd_chk("R4 key write ignored", a, 16'h0000);
      else                     rd_chk("R5 hole reads zero", a, 16'h0000);
    end

    // R7: display port sweep
    for (int i = 0; i < FB_SIZE; i++) begin
      disp_addr = (AW-2)'(i);
      #1;
      chk("R7 display fetch", disp_data, pat(FB_BASE + i, 7));
    end

    // R8: clock edges with we low at each region boundary
    wr(0, 16'hDEAD, 1'b0);             rd_chk("R8 ram low", 0, pat(0, 7));
    wr(FB_BASE - 1, 16'hDEAD, 1'b0);   rd_chk("R8 ram top", FB_BASE - 1, pat(FB_BASE - 1, 7));
    wr(FB_BASE, 16'hDEAD, 1'b0);       rd_chk("R8 fb low", FB_BASE, pat(FB_BASE, 7));
    wr(KEY_ADDR - 1, 16'hDEAD, 1'b0);  rd_chk("R8 fb top", KEY_ADDR - 1, pat(KEY_ADDR - 1, 7));

    // R1 R2: same-cycle combinational readback after boundary overwrites
    wr(FB_BASE - 1, 16'h0F0F, 1'b1);   rd_chk("R1 ram top overwrite", FB_BASE - 1, 16'h0F0F);
    rd_chk("R6 fb low untouched", FB_BASE, pat(FB_BASE, 7));
    wr(FB_BASE, 16'hF0F0, 1'b1);       rd_chk("R2 fb low overwrite", FB_BASE, 16'hF0F0);
    rd_chk("R6 ram top untouched", FB_BASE - 1, 16'h0F0F);
    disp_addr = '0; #1;
    chk("R7 display sees overwrite", disp_data, 16'hF0F0);

    // R3: keyboard register samples key_i on the edge
    @(negedge clk);
    addr = AW'(KEY_ADDR);
    key = 16'h0041;
    #1;
    chk("R3 before edge", rdata, 16'h0000);
    @(posedge clk); #1;
    chk("R3 key pressed", rdata, 16'h0041);
    wr(KEY_ADDR, 16'h7777, 1'b1);
    addr = AW'(KEY_ADDR); #1;
    chk("R4 key write ignored live", rdata, 16'h0041);
    @(negedge clk);
    key = 16'h0000;
    @(posedge clk); #1;
    chk("R3 key released", rdata, 16'h0000);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule